// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block sits behind a UART transmitter and turns its serial bit stream into the short light pulses of serial infrared signalling. Each zero-valued bit on the stream becomes one active-high pulse on the infrared drive output. Each one-valued bit leaves that output low. The pulse width is chosen at run time. In the fractional mode it is three sixteenths of the bit period, measured in 16x oversampling ticks. In the low-power mode it is three periods of a separate reference tick, whatever the bit rate.

The encoder has no bit-start input, so it recovers the bit boundaries from the stream itself. Any change of the stream level seen at a 16x tick starts a new bit. When the level stays the same, a new bit starts every sixteenth tick. Back-to-back zero bits therefore each give their own pulse.

The infrared path works only while both the UART enable and the infrared enable are set. While it works, the ordinary transmit line is parked high, in the marking state. Otherwise the infrared output stays low and the transmit line carries the stream, registered once. Both the 16x tick and the low-power tick are one-cycle enables in the single clock domain.

Top module: `sir_pulse_encoder`

## Requirements
- R1: In fractional mode (`lp_mode_i`=0), a zero bit raises `sir_out_o` on the clock edge that samples the bit-start 16x tick, and lowers it on the edge of the third 16x tick after that, giving a pulse of exactly 3 tick periods.
- R2: A one-valued bit never raises `sir_out_o`.
- R3: In low-power mode (`lp_mode_i`=1), a zero-bit pulse starts at the bit-start edge and ends on the edge of the third low-power tick strictly after it. A low-power tick in the bit-start cycle is not counted.
- R4: With `sir_en_i`=0, `sir_out_o` stays low and `uart_txd_o` equals the value of `tx_bit_i` sampled on the previous clock edge.
- R5: With `sir_en_i`=1 and `uart_en_i`=1, `uart_txd_o` is 1 on the clock edge after each such cycle, whatever `tx_bit_i` is.
- R6: With `uart_en_i`=0, the value of `sir_en_i` has no effect: `sir_out_o` stays low and `uart_txd_o` follows `tx_bit_i` one cycle late.
- R7: A level change of `tx_bit_i` at a 16x tick starts a bit. With no change, a bit starts every 16th tick, so consecutive zero bits each give a full pulse.
- R8: While `rst_n` is low at a clock edge, that edge sets `sir_out_o` to 0 and `uart_txd_o` to 1.
- R9: The low-power pulse width does not depend on the 16x tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_bit_i | input | 1 | Serial transmit bit stream from the UART |
| os_tick_i | input | 1 | One-cycle 16x oversampling tick |
| lp_tick_i | input | 1 | One-cycle low-power reference tick |
| sir_en_i | input | 1 | Infrared path enable |
| uart_en_i | input | 1 | UART enable |
| lp_mode_i | input | 1 | 1 = low-power pulse width, 0 = fractional width |
| sir_out_o | output | 1 | Infrared drive, active high |
| uart_txd_o | output | 1 | Ordinary transmit line |

## Verification
The hardest situation to reach is a run of identical zero bits. With no level change, only the internal 16-tick bit counter marks each boundary, so a wrong phase would merge or drop pulses. The bench sends whole frames, including an all-zero byte, with its ticks on a fixed grid. It counts the high cycles that fall in each bit window and compares them with a width worked out from the tick schedule. It does this in both modes and at two 16x tick rates, so that a wrong low-power width cannot be mistaken for one that follows the bit rate.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

  typedef enum logic {
    PW_FRACTION = 1'b0,
    PW_LOWPOWER = 1'b1
  } pw_mode_e;

  // number of counted ticks that end a pulse in the selected mode
  function automatic int unsigned pulse_limit(input pw_mode_e mode,
                                              input int unsigned frac_ticks,
                                              input int unsigned lp_ticks);
    return (mode == PW_LOWPOWER) ? lp_ticks : frac_ticks;
  endfunction

  // a bit begins on a level change or when the phase wraps
  function automatic logic is_bit_boundary(input logic now_lvl,
                                           input logic prev_lvl,
                                           input logic phase_last);
    return (now_lvl != prev_lvl) || phase_last;
  endfunction

endpackage

// File: rtl/sir_bit_timer.sv
module sir_bit_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic data_i,
  output logic bit_start_o,
  output logic bit_val_o
);
  import sir_enc_pkg::*;

  localparam int unsigned PW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

  logic [PW-1:0] phase_q;
  logic          last_q;
  logic          at_last;

  assign at_last     = (phase_q == PH_LAST);
  assign bit_start_o = tick_i && is_bit_boundary(data_i, last_q, at_last);
  assign bit_val_o   = data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LAST;
      last_q  <= 1'b1;
    end else if (tick_i) begin
      last_q  <= data_i;
      phase_q <= bit_start_o ? '0 : phase_q + 1'b1;
    end
  end

  // R7: each bit start restarts the phase count
  a_r7_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start_o |=> (phase_q == '0));

  // R7: the phase never passes the last slot of a bit
  a_r7_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && tick_i) |=> (phase_q == '0));

endmodule

// File: rtl/sir_pulse_gen.sv
module sir_pulse_gen #(
  parameter int unsigned FRAC_TICKS = 3,
  parameter int unsigned LP_TICKS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic lp_mode_i,
  input  logic bit_start_i,
  input  logic bit_val_i,
  input  logic os_tick_i,
  input  logic lp_tick_i,
  output logic pulse_o
);
  import sir_enc_pkg::*;

  localparam int unsigned MAXT = (FRAC_TICKS > LP_TICKS) ? FRAC_TICKS : LP_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  pw_mode_e      mode;
  logic [CW-1:0] limit;
  logic          step_tick;
  logic          fire;
  logic          pulse_q, pulse_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign mode      = pw_mode_e'(lp_mode_i);
  assign limit     = CW'(pulse_limit(mode, FRAC_TICKS, LP_TICKS));
  assign step_tick = (mode == PW_LOWPOWER) ? lp_tick_i : os_tick_i;
  assign fire      = active_i && bit_start_i && !bit_val_i;

  always_comb begin
    pulse_n = pulse_q;
    cnt_n   = cnt_q;
    if (!active_i) begin
      pulse_n = 1'b0;
      cnt_n   = '0;
    end else if (fire) begin
      pulse_n = 1'b1;
      cnt_n   = '0;
    end else if (pulse_q && step_tick) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_n >= limit) begin
        pulse_n = 1'b0;
        cnt_n   = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pulse_q <= pulse_n;
      cnt_q   <= cnt_n;
    end
  end

  assign pulse_o = pulse_q;

  // R2: a pulse only rises after an active zero-bit start
  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(bit_start_i && !bit_val_i && active_i));

  // R1 / R3: without a counted tick the pulse keeps going
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && active_i && !step_tick) |=> pulse_q);

  // R4: an inactive path leaves the pulse low
  a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !pulse_q);

  // R1 / R3: the tick count stays below its limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXT));

endmodule

// File: rtl/sir_line_drive.sv
module sir_line_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic data_i,
  input  logic pulse_i,
  output logic sir_o,
  output logic txd_o
);
  logic txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) txd_q <= 1'b1;
    else        txd_q <= active_i ? 1'b1 : data_i;
  end

  assign txd_o = txd_q;
  assign sir_o = pulse_i;

  // R5: the transmit line parks high while the infrared path is active
  a_r5_mark: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> txd_o);

  // R8: reset forces the idle levels
  a_r8_reset_levels: assert property (@(posedge clk)
    !rst_n |=> (txd_o && !sir_o));

endmodule

// File: rtl/sir_pulse_encoder.sv
module sir_pulse_encoder #(
  parameter int unsigned OVS        = 16,
  parameter int unsigned FRAC_TICKS = 3,
  parameter int unsigned LP_TICKS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_bit_i,
  input  logic os_tick_i,
  input  logic lp_tick_i,
  input  logic sir_en_i,
  input  logic uart_en_i,
  input  logic lp_mode_i,
  output logic sir_out_o,
  output logic uart_txd_o
);
  logic active;
  logic bit_start;
  logic bit_val;
  logic pulse;

  // R6: the infrared enable only counts while the UART is enabled
  assign active = uart_en_i && sir_en_i;

  sir_bit_timer #(.OVS(OVS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (os_tick_i),
    .data_i      (tx_bit_i),
    .bit_start_o (bit_start),
    .bit_val_o   (bit_val)
  );

  sir_pulse_gen #(.FRAC_TICKS(FRAC_TICKS), .LP_TICKS(LP_TICKS)) u_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .lp_mode_i   (lp_mode_i),
    .bit_start_i (bit_start),
    .bit_val_i   (bit_val),
    .os_tick_i   (os_tick_i),
    .lp_tick_i   (lp_tick_i),
    .pulse_o     (pulse)
  );

  sir_line_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .data_i   (tx_bit_i),
    .pulse_i  (pulse),
    .sir_o    (sir_out_o),
    .txd_o    (uart_txd_o)
  );

  // R6: with the UART off the infrared output stays low
  a_r6_uart_off: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_en_i |=> !sir_out_o);

endmodule

// File: tb/sir_pulse_encoder_bench.sv
module sir_pulse_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LPDIV      = 5;
  localparam int NBITS      = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_bit = 1'b1, os_tick = 1'b0, lp_tick = 1'b0;
  logic sir_en = 1'b0, uart_en = 1'b0, lp_mode = 1'b0;
  logic sir_out, uart_txd;

  int total = 0, bad = 0;
  int gk = 0, bdiv = 4;
  int txd_err = 0;
  logic s_sir, s_txd, prev_tx = 1'b1, prev_act = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_pulse_encoder u_sir_pulse_encoder (
    .clk(clk), .rst_n(rst_n), .tx_bit_i(tx_bit), .os_tick_i(os_tick),
    .lp_tick_i(lp_tick), .sir_en_i(sir_en), .uart_en_i(uart_en),
    .lp_mode_i(lp_mode), .sir_out_o(sir_out), .uart_txd_o(uart_txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: sample results of the last edge, then drive the next inputs
  task automatic drive_cycle(input logic v);
    @(negedge clk);
    s_sir = sir_out;
    s_txd = uart_txd;
    if (rst_n && s_txd !== (prev_act ? 1'b1 : prev_tx)) txd_err++;
    tx_bit  = v;
    os_tick = (gk % bdiv == 0);
    lp_tick = (gk % LPDIV == 0);
    prev_tx = v;
    prev_act = uart_en && sir_en;
    gk++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive_cycle(1'b1);
  endtask

  // send start bit, 8 data bits LSB first, stop bit; check per-bit widths
  task automatic run_frame(input logic [7:0] b, input string req);
    int hi [NBITS];
    int ex [NBITS];
    logic v;
    bit act;
    act = uart_en && sir_en;
    txd_err = 0;
    while (gk % bdiv != 0) drive_cycle(1'b1);
    for (int i = 0; i < NBITS; i++) begin
      hi[i] = 0;
      v = (i == 0) ? 1'b0 : (i == NBITS-1) ? 1'b1 : b[i-1];
      if (!act || v) ex[i] = 0;
      else if (lp_mode) ex[i] = ((gk / LPDIV) + 1) * LPDIV + 2*LPDIV - gk;
      else ex[i] = 3 * bdiv;
      for (int j = 0; j < 16*bdiv; j++) begin
        drive_cycle(v);
        if (j == 0 && i > 0) hi[i-1] += int'(s_sir);
        else if (j > 0) hi[i] += int'(s_sir);
      end
    end
    drive_cycle(1'b1);
    hi[NBITS-1] += int'(s_sir);
    for (int i = 0; i < NBITS; i++)
      check(hi[i] == ex[i], $sformatf("%s bit%0d width", req, i), hi[i], ex[i]);
    check(txd_err == 0, $sformatf("%s txd", req), txd_err, 0);
    idle(20);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sir_en = 1'b1; uart_en = 1'b1;
    for (int k = 0; k < 4; k++) drive_cycle(1'b0);
    drive_cycle(1'b0);
    check(s_sir == 1'b0, "R8 sir in reset", s_sir, 0);
    check(s_txd == 1'b1, "R8 txd in reset", s_txd, 1);
    rst_n = 1'b1; sir_en = 1'b0; uart_en = 1'b0;
    idle(40);
  endtask

  task automatic t_fraction();
    uart_en = 1'b1; sir_en = 1'b1; lp_mode = 1'b0;
    bdiv = 4; idle(8);
    run_frame(8'hA5, "R1 R2 R5 frac div4");
    run_frame(8'h00, "R7 R1 zero run");
    bdiv = 2; idle(8);
    run_frame(8'h3C, "R1 R2 frac div2");
  endtask

  task automatic t_lowpower();
    uart_en = 1'b1; sir_en = 1'b1; lp_mode = 1'b1;
    bdiv = 4; idle(8);
    run_frame(8'h5A, "R3 lp div4");
    bdiv = 2; idle(8);
    run_frame(8'h0F, "R9 R3 lp div2");
    idle(3);
    run_frame(8'h00, "R9 R7 lp zero run");
  endtask

  task automatic t_disabled();
    lp_mode = 1'b0; bdiv = 4;
    uart_en = 1'b1; sir_en = 1'b0; idle(8);
    run_frame(8'h00, "R4 sir off");
    uart_en = 1'b0; sir_en = 1'b1; idle(8);
    run_frame(8'h96, "R6 uart off");
    uart_en = 1'b0; sir_en = 1'b0; idle(8);
    run_frame(8'h00, "R6 R4 both off");
  endtask

  initial begin
    t_reset();
    t_fraction();
    t_lowpower();
    t_disabled();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule